// File: doc/BRIEF.md
# Camera Link Sync-Code Framer

This block sits behind the bit-recovery stage of a serial camera receiver. It takes an already aligned byte stream with a valid flag and looks for four-byte synchronization codes. Each code is an all-ones byte, two all-zero bytes and a descriptor byte. The low nibble of the descriptor gives the event kind. The high nibble gives the logical channel. From these codes the block drives a line-sync level, a frame-sync level and a registered channel number.

A static mode input selects one of two output streams. In pass-through mode every accepted byte is echoed one cycle later. In strip mode every byte passes through a three-entry delay line. The delay line holds a byte until three newer bytes have been accepted, so any possible code prefix has been resolved by the time a byte leaves it. All four bytes of a recognised code are dropped and never reach the output. A prefix that turns out to be false leaves the delay line as ordinary payload, in its original order.

A descriptor whose kind nibble is not one of the four defined values is flagged for one cycle. It has no other effect on the sync state.

Top module: `camsync_framer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hsync`, `vsync`, `out_valid` and `code_err` are 0, `chan` is 0 and the delay line is empty.
- R2: A code is recognised when the accepted bytes (cycles with `in_valid` low are skipped) are 8'hFF, 8'h00, 8'h00 and then a descriptor byte, all accepted since the last recognised code or reset. Its effects are visible in the cycle after the descriptor is accepted.
- R3: Descriptor kind nibble (bits 3:0) value 0 sets `hsync` to 1. Value 1 clears `hsync` to 0.
- R4: Kind value 2 sets `vsync` to 1. Kind value 3 clears `vsync` to 0.
- R5: On a code with kind 0 to 3, `chan` takes descriptor bits 7:4. At all other times `chan` holds its value.
- R6: On a code with kind 4 to 15, `code_err` is 1 for exactly one cycle, and `hsync`, `vsync` and `chan` keep their values.
- R7: With `strip_en` = 0, every byte accepted in one cycle appears on `out_byte` with `out_valid` = 1 in the next cycle, and this includes code bytes.
- R8: With `strip_en` = 1, the output is the byte accepted three accepted bytes earlier, emitted in the cycle after the newer byte is accepted. All four bytes of a code, whatever its kind, are never emitted, and the delay line is emptied.
- R9: In strip mode, a false prefix (for example FF, 00, then a nonzero byte) is emitted as payload in arrival order.
- R10: Codes may overlap a preceding partial prefix. In FF, FF, 00, 00, D the first FF is emitted as payload and the last four bytes form a code.
- R11: A cycle with `in_valid` = 0 produces `out_valid` = 0 in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | 1 | 1 removes code bytes, 0 forwards all bytes |
| in_byte | input | 8 | Aligned input byte |
| in_valid | input | 1 | `in_byte` is accepted this cycle |
| out_byte | output | 8 | Forwarded byte |
| out_valid | output | 1 | `out_byte` is valid |
| hsync | output | 1 | Line-sync level |
| vsync | output | 1 | Frame-sync level |
| chan | output | 4 | Channel of the last valid code |
| code_err | output | 1 | One-cycle flag for an undefined kind |

## Verification
The assertions assume that `strip_en` only changes while reset is asserted. A change while bytes are held would break the relation between output and input that they check. They also assume that `in_valid` is never unknown. The bench fixes the mode before it releases reset in each scenario and drives every input at the falling edge with defined values. Idle cycles are placed inside code prefixes to exercise the rule that skips them.

// File: rtl/camsync_pkg.sv
package camsync_pkg;
  localparam int BYTE_W     = 8;
  localparam int CH_W       = 4;
  localparam int KIND_W     = BYTE_W - CH_W;
  localparam int PREFIX_LEN = 3;

  typedef enum logic [1:0] {
    EV_LINE_START  = 2'd0,
    EV_LINE_END    = 2'd1,
    EV_FRAME_START = 2'd2,
    EV_FRAME_END   = 2'd3
  } sync_event_e;

  // Expected prefix byte, position 0 being the oldest byte of the prefix.
  function automatic logic [BYTE_W-1:0] prefix_byte(input int pos);
    return (pos == 0) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  endfunction

  // Only the four lowest kind values are defined.
  function automatic logic kind_defined(input logic [KIND_W-1:0] k);
    return (k[KIND_W-1:2] == '0);
  endfunction
endpackage

// File: rtl/csf_delay_line.sv
module csf_delay_line #(
  parameter int DW    = camsync_pkg::BYTE_W,
  parameter int DEPTH = camsync_pkg::PREFIX_LEN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic                      flush,
  input  logic [DW-1:0]             din,
  output logic [DEPTH-1:0][DW-1:0]  taps,
  output logic [DEPTH-1:0]          live
);
  // Entry 0 is the newest byte, entry DEPTH-1 the oldest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [DW-1:0] nxt_d;
    logic          nxt_l;
    if (i == 0) begin : g_head
      assign nxt_d = din;
      assign nxt_l = 1'b1;
    end else begin : g_body
      assign nxt_d = taps[i-1];
      assign nxt_l = live[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        taps[i] <= '0;
        live[i] <= 1'b0;
      end else if (flush) begin
        live[i] <= 1'b0;
      end else if (shift) begin
        taps[i] <= nxt_d;
        live[i] <= nxt_l;
      end
    end

    if (i > 0) begin : g_chk
      // R8: occupancy always fills from the newest end
      a_r8_live_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        live[i] |-> live[i-1]);
    end
  end
endmodule

// File: rtl/csf_code_detect.sv
module csf_code_detect #(
  parameter int DW     = camsync_pkg::BYTE_W,
  parameter int DEPTH  = camsync_pkg::PREFIX_LEN,
  parameter int CH_W   = camsync_pkg::CH_W,
  parameter int KIND_W = camsync_pkg::KIND_W
) (
  input  logic [DEPTH-1:0][DW-1:0] taps,
  input  logic [DEPTH-1:0]         live,
  input  logic                     in_valid,
  input  logic [DW-1:0]            din,
  output logic                     hit,
  output logic                     kind_ok,
  output camsync_pkg::sync_event_e kind,
  output logic [CH_W-1:0]          chan_field
);
  logic prefix_seen;

  always_comb begin
    prefix_seen = 1'b1;
    for (int p = 0; p < DEPTH; p++) begin
      if (!live[DEPTH-1-p] || taps[DEPTH-1-p] != camsync_pkg::prefix_byte(p))
        prefix_seen = 1'b0;
    end
  end

  assign hit        = in_valid && prefix_seen;
  assign kind_ok    = camsync_pkg::kind_defined(din[KIND_W-1:0]);
  assign kind       = camsync_pkg::sync_event_e'(din[1:0]);
  assign chan_field = din[DW-1:DW-CH_W];
endmodule

// File: rtl/csf_sync_state.sv
module csf_sync_state #(
  parameter int CH_W = camsync_pkg::CH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit,
  input  logic                     kind_ok,
  input  camsync_pkg::sync_event_e kind,
  input  logic [CH_W-1:0]          chan_field,
  output logic                     hsync,
  output logic                     vsync,
  output logic [CH_W-1:0]          chan,
  output logic                     code_err
);
  import camsync_pkg::*;

  logic good_code;
  logic bad_code;
  assign good_code = hit && kind_ok;
  assign bad_code  = hit && !kind_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      chan     <= '0;
      code_err <= 1'b0;
    end else begin
      code_err <= bad_code;
      if (good_code) begin
        chan <= chan_field;
        unique case (kind)
          EV_LINE_START:  hsync <= 1'b1;
          EV_LINE_END:    hsync <= 1'b0;
          EV_FRAME_START: vsync <= 1'b1;
          EV_FRAME_END:   vsync <= 1'b0;
        endcase
      end
    end
  end

  // R6: the error flag never lasts two cycles
  a_r6_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> !code_err);
  // R6: an undefined kind leaves the sync state alone
  a_r6_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> ($stable(hsync) && $stable(vsync) && $stable(chan)));
  // R5: channel moves only after a defined code
  a_r5_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !good_code |=> $stable(chan));
  // R3: a rising line sync needs a line-start code
  a_r3_hsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> $past(good_code && kind == EV_LINE_START));
  // R4: a falling frame sync needs a frame-end code
  a_r4_vsync_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> $past(good_code && kind == EV_FRAME_END));
endmodule

// File: rtl/csf_out_stage.sv
module csf_out_stage #(
  parameter int DW = camsync_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strip_en,
  input  logic          in_valid,
  input  logic [DW-1:0] din,
  input  logic          hit,
  input  logic [DW-1:0] oldest,
  input  logic          oldest_live,
  output logic [DW-1:0] out_byte,
  output logic          out_valid
);
  logic          pop_payload;
  logic [DW-1:0] pick;
  logic          pick_valid;

  assign pop_payload = in_valid && !hit && oldest_live;
  assign pick        = strip_en ? oldest : din;
  assign pick_valid  = strip_en ? pop_payload : in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pick_valid;
      if (pick_valid) out_byte <= pick;
    end
  end

  // R8: the cycle after a recognised code emits nothing in strip mode
  a_r8_code_withheld: assert property (@(posedge clk) disable iff (!rst_n)
    (strip_en && hit) |=> !out_valid);
  // R7: pass-through echoes each accepted byte one cycle later
  a_r7_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (!strip_en && in_valid) |=> (out_valid && out_byte == $past(din)));
endmodule

// File: rtl/camsync_framer.sv
module camsync_framer #(
  parameter int DW    = camsync_pkg::BYTE_W,
  parameter int CH_W  = camsync_pkg::CH_W,
  parameter int DEPTH = camsync_pkg::PREFIX_LEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strip_en,
  input  logic [DW-1:0]   in_byte,
  input  logic            in_valid,
  output logic [DW-1:0]   out_byte,
  output logic            out_valid,
  output logic            hsync,
  output logic            vsync,
  output logic [CH_W-1:0] chan,
  output logic            code_err
);
  localparam int KIND_W = DW - CH_W;

  // Named internal events
  logic [DEPTH-1:0][DW-1:0]  ev_taps;
  logic [DEPTH-1:0]          ev_live;
  logic                      ev_code_hit;
  logic                      ev_kind_ok;
  camsync_pkg::sync_event_e  ev_kind;
  logic [CH_W-1:0]           ev_chan_field;

  csf_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (in_valid),
    .flush (ev_code_hit),
    .din   (in_byte),
    .taps  (ev_taps),
    .live  (ev_live)
  );

  csf_code_detect #(.DW(DW), .DEPTH(DEPTH), .CH_W(CH_W), .KIND_W(KIND_W)) u_det (
    .taps       (ev_taps),
    .live       (ev_live),
    .in_valid   (in_valid),
    .din        (in_byte),
    .hit        (ev_code_hit),
    .kind_ok    (ev_kind_ok),
    .kind       (ev_kind),
    .chan_field (ev_chan_field)
  );

  csf_sync_state #(.CH_W(CH_W)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (ev_code_hit),
    .kind_ok    (ev_kind_ok),
    .kind       (ev_kind),
    .chan_field (ev_chan_field),
    .hsync      (hsync),
    .vsync      (vsync),
    .chan       (chan),
    .code_err   (code_err)
  );

  csf_out_stage #(.DW(DW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .strip_en    (strip_en),
    .in_valid    (in_valid),
    .din         (in_byte),
    .hit         (ev_code_hit),
    .oldest      (ev_taps[DEPTH-1]),
    .oldest_live (ev_live[DEPTH-1]),
    .out_byte    (out_byte),
    .out_valid   (out_valid)
  );

  // R11: an idle input cycle yields an idle output cycle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11: idle cycles leave the sync levels untouched
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(hsync) && $stable(vsync) && $stable(chan)));
  // R2: the error flag is raised only after a prefix match
  a_r2_err_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_err) |-> $past(ev_code_hit));
endmodule

// File: tb/camsync_framer_bench.sv
`timescale 1ns/1ps
module camsync_framer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strip_en;
  logic [7:0] in_byte;
  logic       in_valid;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       hsync, vsync, code_err;
  logic [3:0] chan;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap [0:31];
  int ncap;

  always #2.5 clk = ~clk;

  camsync_framer u_camsync_framer (
    .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .in_byte(in_byte),
    .in_valid(in_valid), .out_byte(out_byte), .out_valid(out_valid),
    .hsync(hsync), .vsync(vsync), .chan(chan), .code_err(code_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; strip_en = mode; in_valid = 1'b0; in_byte = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ncap = 0;
  endtask

  // One accepted byte; outputs sampled just after the edge that takes it.
  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_byte = b; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (out_valid && ncap < 32) begin cap[ncap] = out_byte; ncap++; end
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'hFF;
    @(posedge clk); #1;
    chk("R11 idle out_valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    @(posedge clk); #1;
    chk("R1 hsync", {31'd0, hsync}, 0);
    chk("R1 vsync", {31'd0, vsync}, 0);
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    chk("R1 code_err", {31'd0, code_err}, 0);
    chk("R1 chan", {28'd0, chan}, 0);
  endtask

  task automatic t_passthrough;
    logic [7:0] seq [0:9];
    seq = '{8'hFF, 8'h00, 8'h00, 8'h30, 8'hAA, 8'hBB, 8'hFF, 8'h00, 8'h00, 8'h31};
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) begin
      push(seq[i]);
      chk("R7 echo valid", {31'd0, out_valid}, 1);
      chk("R7 echo byte", {24'd0, out_byte}, {24'd0, seq[i]});
      if (i == 3) begin
        chk("R3 hsync set", {31'd0, hsync}, 1);
        chk("R5 chan load", {28'd0, chan}, 3);
      end
      if (i == 5) chk("R3 hsync held", {31'd0, hsync}, 1);
    end
    chk("R3 hsync cleared", {31'd0, hsync}, 0);
    chk("R4 vsync untouched", {31'd0, vsync}, 0);
  endtask

  task automatic t_strip;
    logic [7:0] seq [0:10];
    seq = '{8'h11, 8'h22, 8'h33, 8'hFF, 8'h00, 8'h00, 8'h52, 8'h44, 8'h55, 8'h66, 8'h77};
    do_reset(1'b1);
    for (int i = 0; i < 11; i++) begin
      push(seq[i]);
      if (i == 6) begin
        chk("R8 code withheld", {31'd0, out_valid}, 0);
        chk("R4 vsync set", {31'd0, vsync}, 1);
        chk("R5 chan from code", {28'd0, chan}, 5);
      end
    end
    chk("R8 payload count", ncap, 4);
    chk("R8 payload 0", {24'd0, cap[0]}, 32'h11);
    chk("R8 payload 1", {24'd0, cap[1]}, 32'h22);
    chk("R8 payload 2", {24'd0, cap[2]}, 32'h33);
    chk("R8 payload 3", {24'd0, cap[3]}, 32'h44);
  endtask

  task automatic t_false_prefix;
    logic [7:0] seq [0:6];
    seq = '{8'hFF, 8'h00, 8'h55, 8'h01, 8'h02, 8'h03, 8'h04};
    do_reset(1'b1);
    for (int i = 0; i < 7; i++) push(seq[i]);
    chk("R9 count", ncap, 4);
    chk("R9 byte 0", {24'd0, cap[0]}, 32'hFF);
    chk("R9 byte 1", {24'd0, cap[1]}, 32'h00);
    chk("R9 byte 2", {24'd0, cap[2]}, 32'h55);
    chk("R9 byte 3", {24'd0, cap[3]}, 32'h01);
    chk("R9 no sync", {30'd0, hsync, vsync}, 0);
  endtask

  task automatic t_overlap;
    logic [7:0] seq [0:12];
    seq = '{8'hFF, 8'h00, 8'h00, 8'h02, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h23,
            8'hA1, 8'hA2, 8'hA3, 8'hA4};
    do_reset(1'b1);
    for (int i = 0; i < 13; i++) begin
      push(seq[i]);
      if (i == 3) chk("R4 vsync set", {31'd0, vsync}, 1);
    end
    chk("R10 vsync cleared", {31'd0, vsync}, 0);
    chk("R10 chan", {28'd0, chan}, 2);
    chk("R10 count", ncap, 2);
    chk("R10 lead FF", {24'd0, cap[0]}, 32'hFF);
    chk("R10 next payload", {24'd0, cap[1]}, 32'hA1);
  endtask

  task automatic t_invalid;
    do_reset(1'b0);
    push(8'hFF); push(8'h00); push(8'h00); push(8'h10);
    chk("R3 hsync set", {31'd0, hsync}, 1);
    push(8'hFF); push(8'h00); push(8'h00); push(8'h77);
    chk("R6 err raised", {31'd0, code_err}, 1);
    chk("R6 hsync kept", {31'd0, hsync}, 1);
    chk("R6 chan kept", {28'd0, chan}, 1);
    idle;
    chk("R6 err dropped", {31'd0, code_err}, 0);
    do_reset(1'b1);
    push(8'hFF); push(8'h00); push(8'h00); push(8'h0F);
    push(8'h61); push(8'h62); push(8'h63); push(8'h64);
    chk("R8 bad code stripped count", ncap, 1);
    chk("R8 bad code stripped byte", {24'd0, cap[0]}, 32'h61);
  endtask

  task automatic t_idle_gaps;
    do_reset(1'b0);
    push(8'hFF); idle; push(8'h00); idle; idle; push(8'h00); idle;
    push(8'h92);
    chk("R2 code across gaps", {31'd0, vsync}, 1);
    chk("R2 chan across gaps", {28'd0, chan}, 9);
    idle;
    chk("R11 vsync stable", {31'd0, vsync}, 1);
    push(8'hFF); push(8'h00); push(8'h12); push(8'h00);
    chk("R2 broken prefix", {31'd0, hsync}, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strip_en = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    t_reset;
    t_passthrough;
    t_strip;
    t_false_prefix;
    t_overlap;
    t_invalid;
    t_idle_gaps;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule